// File: doc/BRIEF.md
# Timer Compare Channel with Output Modes

This block is one compare channel that sits beside a free-running time counter. Software programs a compare value. The counter signals each step it takes with an advance strobe. When it lands on the programmed value, the channel raises a status flag. It can also raise an interrupt or a DMA request, and it drives an event pin in the way the selected mode asks: it either inverts the pin or emits a one-clock high pulse.

The compare register holds two values. The first value written after the channel is disabled becomes the armed value. A second write is queued behind it. The queued value moves into the armed slot at the moment the armed value matches. Software can therefore keep one edge queued while another is pending, and build a periodic waveform by feeding a new compare value after each match. The control word holds the mode, the interrupt enable, the DMA enable and the write-1-to-clear flag. Writing a control word whose mode field is zero turns the channel off and empties both compare slots.

Top module: `tcc_compare_chan`

## Requirements
- R1: After reset, the control readback, `evt_pin`, `irq` and `dma_req` are all zero.
- R2: The control word maps its bits as follows: bit 0 is the DMA enable, bits 5:2 are the mode, bit 6 is the interrupt enable and bit 7 is the flag. Bit 1 and all bits above 7 read as zero and ignore writes. A control write loads bit 0 and bits 6:2 in the next cycle.
- R3: A match needs four things in the same cycle: `cnt_tick` is high, the mode is nonzero, an armed value is present, and `cnt_val` equals the armed value. A compare write keeps only the low CNT_W bits.
- R4: The flag reads 1 in the cycle after a match. A control write with bit 7 set clears it, and a write with bit 7 clear leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag stays set.
- R5: `irq` equals flag AND interrupt enable, and `dma_req` equals flag AND DMA enable. Both follow the registered control state.
- R6: A compare write goes into the armed slot when that slot is empty, and into the queued slot otherwise. A later write replaces a queued value that has not yet been promoted. On a match, the queued value becomes armed. With no value queued, the armed slot empties and no further match occurs.
- R7: In mode 0x5, `evt_pin` inverts in the cycle after each match.
- R8: In mode 0xF, `evt_pin` is high for exactly the one cycle after a match and low otherwise.
- R9: A control write with mode 0 drives `evt_pin` low in the next cycle and empties both compare slots. The next compare write then arms anew.
- R10: In any other nonzero mode, a match sets the flag but `evt_pin` keeps its value.
- R11: Matching works across the counter wrap: an armed value of 2^CNT_W-1 followed by a queued value of 0 produces two matches on consecutive counter steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Time counter advanced this cycle |
| cnt_val | input | CNT_W | Current time counter value |
| reg_wr | input | 1 | Register write strobe |
| reg_is_cmp | input | 1 | 1 selects the compare register, 0 the control word |
| reg_wdata | input | DATA_W | Write data |
| ctl_rdata | output | DATA_W | Control word readback |
| evt_pin | output | 1 | Event pin output |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the channel with CNT_W = 12 and the default DATA_W = 32. This puts the counter's top value 4095 and the wrap to zero within a handful of driven cycles, so R11 is exercised directly. A compare write with bit 12 set shows that the bits above the counter width are dropped. The 32-bit data path is kept so that writes with the upper bits set show that those bits are ignored in the control readback.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
  localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

  // Control word, bit 7 down to bit 0
  typedef struct packed {
    logic              flag;
    logic              ie;
    logic [MODE_W-1:0] mode;
    logic              rsvd;
    logic              dre;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/tcc_ctl_reg.sv
module tcc_ctl_reg
  import tcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wdata,
  input  logic             match_i,
  output ctl_t             ctl_q,
  output logic [MODE_W-1:0] mode_nxt,
  output logic             flush_o,
  output logic             irq_o,
  output logic             dma_o
);

  ctl_t ctl_d;
  ctl_t wr_word;

  assign wr_word = ctl_t'(wdata);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.dre  = wr_word.dre;
      ctl_d.mode = wr_word.mode;
      ctl_d.ie   = wr_word.ie;
      ctl_d.rsvd = 1'b0;
      if (wr_word.flag) ctl_d.flag = 1'b0;
    end
    // a match in the same cycle overrides a clearing write
    if (match_i) ctl_d.flag = 1'b1;
  end

  assign mode_nxt = ctl_d.mode;
  assign flush_o  = wr_ctl && (wr_word.mode == MODE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      irq_o <= 1'b0;
      dma_o <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      irq_o <= ctl_d.flag & ctl_d.ie;
      dma_o <= ctl_d.flag & ctl_d.dre;
    end
  end

  // R4: a match is always visible as a set flag one cycle later
  a_r4_flag_after_match: assert property (@(posedge clk) disable iff (rst)
    match_i |=> ctl_q.flag);

  // R4: with no match and no write, the flag holds its value
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (!match_i && !wr_ctl) |=> $stable(ctl_q.flag));

  // R5: the interrupt follows flag and enable
  a_r5_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ctl_q.flag && ctl_q.ie));

  // R2: the spare bit never reads back set
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.rsvd);

endmodule

// File: rtl/tcc_cmp_slots.sv
module tcc_cmp_slots #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  input  logic             flush,
  input  logic             enable,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             match_o
);

  logic [CNT_W-1:0] act_q, act_d, nxt_q, nxt_d;
  logic             act_vld, act_vld_d, nxt_vld, nxt_vld_d;

  assign match_o = enable && cnt_tick && act_vld && (cnt_val == act_q);

  always_comb begin
    act_d     = act_q;
    nxt_d     = nxt_q;
    act_vld_d = act_vld;
    nxt_vld_d = nxt_vld;
    if (match_o) begin
      if (nxt_vld) begin
        act_d     = nxt_q;
        act_vld_d = 1'b1;
        nxt_vld_d = 1'b0;
      end else begin
        act_vld_d = 1'b0;
      end
    end
    if (flush) begin
      act_vld_d = 1'b0;
      nxt_vld_d = 1'b0;
    end else if (wr_cmp) begin
      if (!act_vld_d) begin
        act_d     = wdata;
        act_vld_d = 1'b1;
      end else begin
        nxt_d     = wdata;
        nxt_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      nxt_q   <= '0;
      act_vld <= 1'b0;
      nxt_vld <= 1'b0;
    end else begin
      act_q   <= act_d;
      nxt_q   <= nxt_d;
      act_vld <= act_vld_d;
      nxt_vld <= nxt_vld_d;
    end
  end

  // R6: a queued value is armed right after the match
  a_r6_promote: assert property (@(posedge clk) disable iff (rst)
    (match_o && nxt_vld && !flush && !wr_cmp) |=> (act_vld && act_q == $past(nxt_q) && !nxt_vld));

  // R6: with nothing queued, the armed slot drains
  a_r6_drain: assert property (@(posedge clk) disable iff (rst)
    (match_o && !nxt_vld && !wr_cmp) |=> !act_vld);

  // R9: a disabling write empties both slots
  a_r9_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!act_vld && !nxt_vld));

  // R6: the queued slot is never filled while the armed slot is empty
  a_r6_order: assert property (@(posedge clk) disable iff (rst)
    nxt_vld |-> act_vld);

endmodule

// File: rtl/tcc_pin_gen.sv
module tcc_pin_gen
  import tcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_cur,
  input  logic [MODE_W-1:0] mode_nxt,
  input  logic              match_i,
  output logic              pin_o
);

  logic pin_d;

  always_comb begin
    unique case (mode_cur)
      MODE_TOGGLE: pin_d = match_i ? ~pin_o : pin_o;
      MODE_PULSE:  pin_d = match_i;
      MODE_OFF:    pin_d = 1'b0;
      default:     pin_d = pin_o;
    endcase
    if (mode_nxt == MODE_OFF) pin_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else     pin_o <= pin_d;
  end

  // R7: toggle mode inverts the pin on a match
  a_r7_toggle_flip: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == MODE_TOGGLE && match_i && mode_nxt != MODE_OFF) |=> (pin_o != $past(pin_o)));

  // R8: pulse mode returns low when no match occurred
  a_r8_pulse_short: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == MODE_PULSE && !match_i) |=> !pin_o);

  // R9: disabling forces the pin low
  a_r9_off_low: assert property (@(posedge clk) disable iff (rst)
    (mode_nxt == MODE_OFF) |=> !pin_o);

  // R10: other modes never move the pin
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_cur != MODE_TOGGLE && mode_cur != MODE_PULSE && mode_cur != MODE_OFF &&
     mode_nxt != MODE_OFF) |=> $stable(pin_o));

endmodule

// File: rtl/tcc_compare_chan.sv
module tcc_compare_chan
  import tcc_pkg::*;
#(
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              reg_wr,
  input  logic              reg_is_cmp,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              evt_pin,
  output logic              irq,
  output logic              dma_req
);

  localparam int PAD_W = DATA_W - CTL_W;

  ctl_t              ctl_q;
  logic [MODE_W-1:0] mode_nxt;
  logic              flush;
  logic              match;
  logic              wr_ctl, wr_cmp;
  logic              unused_wdata;

  assign wr_ctl       = reg_wr && !reg_is_cmp;
  assign wr_cmp       = reg_wr &&  reg_is_cmp;
  assign unused_wdata = ^reg_wdata;

  tcc_ctl_reg u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctl   (wr_ctl),
    .wdata    (reg_wdata[CTL_W-1:0]),
    .match_i  (match),
    .ctl_q    (ctl_q),
    .mode_nxt (mode_nxt),
    .flush_o  (flush),
    .irq_o    (irq),
    .dma_o    (dma_req)
  );

  tcc_cmp_slots #(.CNT_W(CNT_W)) u_slots (
    .clk      (clk),
    .rst      (rst),
    .wr_cmp   (wr_cmp),
    .wdata    (reg_wdata[CNT_W-1:0]),
    .flush    (flush),
    .enable   (ctl_q.mode != MODE_OFF),
    .cnt_tick (cnt_tick),
    .cnt_val  (cnt_val),
    .match_o  (match)
  );

  tcc_pin_gen u_pin (
    .clk      (clk),
    .rst      (rst),
    .mode_cur (ctl_q.mode),
    .mode_nxt (mode_nxt),
    .match_i  (match),
    .pin_o    (evt_pin)
  );

  assign ctl_rdata = {{PAD_W{1'b0}}, ctl_q};

  // R3: no match while the channel is disabled
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.mode == MODE_OFF) |-> !match);

  // R5: DMA request follows flag and enable
  a_r5_dma_tracks: assert property (@(posedge clk) disable iff (rst)
    dma_req == (ctl_q.flag && ctl_q.dre));

endmodule

// File: tb/tcc_compare_chan_tb.sv
`timescale 1ns/1ps
module tcc_compare_chan_tb_top;

  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cnt_tick = 1'b0;
  logic [CNT_W-1:0]  cnt_val = '0;
  logic              reg_wr = 1'b0;
  logic              reg_is_cmp = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] ctl_rdata;
  logic              evt_pin, irq, dma_req;

  always #2.5 clk = ~clk;

  tcc_compare_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .reg_wr(reg_wr), .reg_is_cmp(reg_is_cmp), .reg_wdata(reg_wdata),
    .ctl_rdata(ctl_rdata), .evt_pin(evt_pin), .irq(irq), .dma_req(dma_req)
  );

  typedef struct {
    int          due;
    logic [34:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: observe {dma, irq, pin, readback} away from the edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [34:0] got;
      it  = sb.pop_front();
      got = {dma_req, irq, evt_pin, ctl_rdata};
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got dma/irq/pin/ctl=%b/%b/%b/%h expected %b/%b/%b/%h",
                 it.tag, got[34], got[33], got[32], got[31:0],
                 it.exp[34], it.exp[33], it.exp[32], it.exp[31:0]);
      end
    end
  end

  task automatic expect_nx(input bit d, input bit i, input bit p,
                           input logic [31:0] c, input string tag);
    item_t it;
    it.due = cyc + 1;
    it.exp = {d, i, p, c};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic op(input bit wr, input bit is_cmp, input logic [31:0] wd,
                    input bit tick, input int cv);
    reg_wr     = wr;
    reg_is_cmp = is_cmp;
    reg_wdata  = wd;
    cnt_tick   = tick;
    cnt_val    = CNT_W'(cv);
    @(negedge clk);
    reg_wr   = 1'b0;
    cnt_tick = 1'b0;
  endtask

  task automatic wr_ctl(input logic [31:0] wd); op(1'b1, 1'b0, wd, 1'b0, 0); endtask
  task automatic wr_cmp(input logic [31:0] wd); op(1'b1, 1'b1, wd, 1'b0, 0); endtask
  task automatic tick(input int cv);            op(1'b0, 1'b0, 0, 1'b1, cv); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    expect_nx(0,0,0,32'h00,"R1 reset state"); op(0,0,0,0,0);
    expect_nx(0,0,0,32'h00,"R9 disable"); wr_ctl(32'h0);
    wr_cmp(100);
    expect_nx(0,0,0,32'h00,"R6 load"); wr_cmp(110);
    expect_nx(0,0,0,32'h54,"R2 field layout"); wr_ctl(32'hFFFFFF56);
    expect_nx(0,0,0,32'h54,"R3 unequal"); tick(99);
    expect_nx(0,1,1,32'hD4,"R7 toggle high"); tick(100);
    expect_nx(0,1,1,32'hD4,"R3 no tick"); op(0,0,0,0,110);
    expect_nx(0,0,1,32'h54,"R4 w1c"); wr_ctl(32'hD4);
    expect_nx(0,1,0,32'hD4,"R6 promoted"); tick(110);
    expect_nx(0,1,0,32'hD4,"R4 write0 keeps"); wr_ctl(32'h54);
    expect_nx(0,0,0,32'h54,"R4 w1c"); wr_ctl(32'hD4);
    expect_nx(0,0,0,32'h54,"R6 drained"); tick(110);

    wr_cmp(200); wr_cmp(210);
    expect_nx(0,0,0,32'h54,"R6 queue"); wr_cmp(220);
    expect_nx(0,1,1,32'hD4,"R7 toggle"); tick(200);
    wr_ctl(32'hD4);
    expect_nx(0,0,1,32'h54,"R6 replaced"); tick(210);
    expect_nx(0,1,0,32'hD4,"R6 replacement"); tick(220);

    wr_cmp(230);
    expect_nx(0,1,1,32'hD4,"R7 toggle"); tick(230);
    wr_cmp(240);
    expect_nx(0,0,0,32'h00,"R9 pin low"); wr_ctl(32'h80);
    wr_ctl(32'h54);
    expect_nx(0,0,0,32'h54,"R9 slots flushed"); tick(240);

    wr_ctl(32'h80); wr_cmp(300); wr_cmp(310);
    expect_nx(0,0,0,32'h3D,"R2 pulse mode"); wr_ctl(32'h3D);
    expect_nx(1,0,1,32'hBD,"R8 pulse"); tick(300);
    expect_nx(1,0,0,32'hBD,"R8 one cycle"); tick(301);
    expect_nx(1,0,1,32'hBD,"R4 set wins"); op(1,0,32'hBD,1,310);
    expect_nx(0,0,0,32'h3D,"R5 dma drop"); wr_ctl(32'hBD);

    wr_ctl(32'h80); wr_cmp(500);
    wr_ctl(32'h44);
    expect_nx(0,1,0,32'hC4,"R10 flag only"); tick(500);

    wr_ctl(32'h80); wr_cmp(32'h1FFF); wr_cmp(0);
    expect_nx(0,0,0,32'h54,"R2 re-enable"); wr_ctl(32'h54);
    expect_nx(0,1,1,32'hD4,"R11 top value"); tick(4095);
    wr_ctl(32'hD4);
    expect_nx(0,1,0,32'hD4,"R11 after wrap"); tick(0);

    wr_ctl(32'h80); wr_cmp(600);
    expect_nx(0,0,0,32'h00,"R3 disabled"); tick(600);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule